// File: doc/BRIEF.md
# Bus Data Phase Scheduler

This block times the data phases on a shared, bidirectional processor data bus. A command source hands it one command at a time: either a read return (the bus will carry data toward the processor) or a write (the bus carries data from the processor). Each data phase starts a programmable number of clocks after its command is accepted. The phase then runs for a fixed number of beats. The block marks every beat with a valid strobe and a direction bit. It does not move the payload itself.

When consecutive phases go in opposite directions, the bus drivers need dead cycles to turn around. Separate programmable minimum gaps apply after a write phase and after a read phase. If the delay requested by a command would start its data too soon, the start is pushed back until the gap is met. Meanwhile `cmd_ready` stays low, so the source sees the extra wait.

The timing fields live in one control word. This word is loaded from strap pins while reset is held. Software may rewrite it later, but a rewrite only takes effect once the scheduler is idle. The scheduler is a three-state machine:
- IDLE: ready for a command.
- WAIT: counting down the start delay and/or the turnaround gap.
- XFER: driving beats.

Its transitions are:
- IDLE→XFER: the command is accepted, its delay is one clock and no gap is owed.
- IDLE→WAIT: the command is accepted, and either its delay is longer or a gap is owed.
- WAIT→XFER: the delay has run out and the gap is satisfied.
- XFER→XFER: a new command is accepted on the last beat and can launch at once. The phase also stays in XFER between beats.
- XFER→WAIT: a command is accepted on the last beat but must wait.
- XFER→IDLE: the last beat passes with no command.

Top module: `bus_data_sched`

## Requirements
- R1: While `rst_n` is low, the strap inputs become the active timing word. After reset `cmd_ready` is 1, `data_vld` is 0 and `cfg_err` is 0.
- R2: For a read-return command, a read-delay code of 1, 2 or 3 puts the first beat that many clocks after the cycle in which the command was accepted.
- R3: For a write command, the first beat comes (write-delay code + 1) clocks after acceptance, a range of 1 to 16.
- R4: A read-delay code of 0 is reserved. It acts as a 1-clock delay and sets `cfg_err` one cycle after it becomes active. `cfg_err` then stays set until reset, and valid codes never set it.
- R5: Every data phase consists of exactly BEATS (default 4) consecutive cycles with `data_vld` high. `data_wr` is 1 for write phases and 0 for read phases, and `data_wr` is 0 whenever `data_vld` is 0.
- R6: After a write phase, a read phase begins only after at least (write-to-read gap field) idle cycles, that is 0 or 1.
- R7: After a read phase, a write phase begins only after at least (read-to-write gap field) idle cycles, that is 0 to 3.
- R8: No gap is owed between phases in the same direction. In general the idle count between back-to-back phases is max(delay − 1, owed gap).
- R9: `cmd_ready` is high only in IDLE or on the last beat of a phase. A command is accepted when `cmd_valid` and `cmd_ready` are both high, and phases follow in acceptance order.
- R10: The timing word layout is: bits [1:0] read delay, [5:2] write delay, [6] write-to-read gap, [8:7] read-to-write gap. A word written with `cfg_we` only takes effect once the scheduler is in IDLE, so a command accepted on the last beat of a phase still uses the old timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset; straps are loaded while low |
| strap_rd_dly | input | 2 | Strap value of the read-return delay code |
| strap_wr_dly | input | 4 | Strap value of the write delay code |
| strap_w2r_gap | input | 1 | Strap value of the write-to-read gap |
| strap_r2w_gap | input | 2 | Strap value of the read-to-write gap |
| cfg_we | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 9 | New timing word (layout in R10) |
| cmd_valid | input | 1 | A command is offered |
| cmd_is_wr | input | 1 | 1 = write command, 0 = read return |
| cmd_ready | output | 1 | Scheduler can take a command this cycle |
| data_vld | output | 1 | A data beat occupies the bus this cycle |
| data_wr | output | 1 | Direction of the current beat (1 = write) |
| cfg_err | output | 1 | Sticky flag: reserved read-delay code was active |

## Verification
Two things can fall in the same cycle: accepting the next command and finishing the current phase. Both happen on the last beat, and that is also the cycle where the block must decide whether the new phase may launch or owes a turnaround gap. The bench provokes this by holding `cmd_valid` across a phase, with the second command's direction and the timing word taken from a vector table. It then judges the result by three measurements: the acceptance cycle must be the last beat, the idle count between the two phases must equal max(delay − 1, owed gap), and each phase's direction bit must match its command. A register write landing while such a pair is in flight is checked in the same way: the pair must show the old timing.

// File: rtl/bds_pkg.sv
`timescale 1ns/1ps
package bds_pkg;

    localparam int DLY_W   = 5;
    localparam int GAP_W   = 2;
    localparam int GAP_MAX = (1 << GAP_W) - 1;

    typedef struct packed {
        logic [1:0] r2w_gap;
        logic       w2r_gap;
        logic [3:0] wr_code;
        logic [1:0] rd_code;
    } bds_cfg_t;

    localparam int CFG_W = $bits(bds_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } bds_state_e;

    // Start delay in clocks; the reserved read code falls back to one clock.
    function automatic logic [DLY_W-1:0] start_delay(bds_cfg_t c, logic is_wr);
        if (is_wr)
            return DLY_W'(c.wr_code) + DLY_W'(1);
        else if (c.rd_code == 2'b00)
            return DLY_W'(1);
        else
            return DLY_W'(c.rd_code);
    endfunction

    // Idle cycles owed after a phase in direction prev_wr when switching.
    function automatic logic [GAP_W-1:0] turn_gap(bds_cfg_t c, logic prev_wr);
        return prev_wr ? GAP_W'(c.w2r_gap) : c.r2w_gap;
    endfunction

endpackage

// File: rtl/bds_cfg_reg.sv
`timescale 1ns/1ps
module bds_cfg_reg
    import bds_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bds_cfg_t strap_cfg,
    input  logic     wr_en,
    input  bds_cfg_t wr_data,
    input  logic     path_idle,
    output bds_cfg_t active,
    output logic     rsvd_err
);

    bds_cfg_t pend_q;
    logic     pend_vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active     <= strap_cfg;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            rsvd_err   <= 1'b0;
        end else begin
            if (path_idle && pend_vld_q)
                active <= pend_q;
            if (wr_en) begin
                pend_q     <= wr_data;
                pend_vld_q <= 1'b1;
            end else if (path_idle) begin
                pend_vld_q <= 1'b0;
            end
            if (active.rd_code == 2'b00)
                rsvd_err <= 1'b1;
        end
    end

endmodule

// File: rtl/bds_turnaround.sv
`timescale 1ns/1ps
module bds_turnaround
    import bds_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             beat_wr,
    output logic [GAP_W-1:0] idle_next,
    output logic             prev_wr
);

    logic [GAP_W-1:0] idle_q;
    logic             last_wr_q;

    // Idle cycles since the last beat as seen by the following cycle.
    always_comb begin
        if (beat)
            idle_next = '0;
        else if (idle_q == GAP_W'(GAP_MAX))
            idle_next = idle_q;
        else
            idle_next = idle_q + GAP_W'(1);
        prev_wr = beat ? beat_wr : last_wr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q    <= GAP_W'(GAP_MAX);
            last_wr_q <= 1'b0;
        end else begin
            idle_q    <= idle_next;
            last_wr_q <= prev_wr;
        end
    end

endmodule

// File: rtl/bus_data_sched.sv
`timescale 1ns/1ps
module bus_data_sched
    import bds_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap_rd_dly,
    input  logic [3:0]       strap_wr_dly,
    input  logic             strap_w2r_gap,
    input  logic [1:0]       strap_r2w_gap,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cmd_valid,
    input  logic             cmd_is_wr,
    output logic             cmd_ready,
    output logic             data_vld,
    output logic             data_wr,
    output logic             cfg_err
);

    localparam int              BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    bds_state_e        state_q, state_d;
    logic [DLY_W-1:0]  dly_q, dly_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              wr_q, wr_d;

    bds_cfg_t          strap_cfg, act_cfg;
    logic [GAP_W-1:0]  gap_idle;
    logic              prev_wr;
    logic              accept, start_wr, gap_ok, fast_go;
    logic [DLY_W-1:0]  req_dly, dly_load;

    assign strap_cfg = {strap_r2w_gap, strap_w2r_gap, strap_wr_dly, strap_rd_dly};

    bds_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_cfg (strap_cfg),
        .wr_en     (cfg_we),
        .wr_data   (bds_cfg_t'(cfg_wdata)),
        .path_idle (state_q == ST_IDLE),
        .active    (act_cfg),
        .rsvd_err  (cfg_err)
    );

    bds_turnaround u_turn (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (data_vld),
        .beat_wr   (wr_q),
        .idle_next (gap_idle),
        .prev_wr   (prev_wr)
    );

    // Launch qualification shared by the accept path and the WAIT state.
    assign accept   = cmd_valid && cmd_ready;
    assign req_dly  = start_delay(act_cfg, cmd_is_wr);
    assign dly_load = (req_dly > DLY_W'(1)) ? req_dly - DLY_W'(2) : '0;
    assign start_wr = (state_q == ST_WAIT) ? wr_q : cmd_is_wr;
    assign gap_ok   = (start_wr == prev_wr) || (gap_idle >= turn_gap(act_cfg, prev_wr));
    assign fast_go  = (req_dly == DLY_W'(1)) && gap_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dly_q   <= '0;
            beat_q  <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            dly_q   <= dly_d;
            beat_q  <= beat_d;
            wr_q    <= wr_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        dly_d   = dly_q;
        beat_d  = beat_q;
        wr_d    = wr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    wr_d    = cmd_is_wr;
                    dly_d   = dly_load;
                    beat_d  = '0;
                    state_d = fast_go ? ST_XFER : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (dly_q != '0) begin
                    dly_d = dly_q - DLY_W'(1);
                end else if (gap_ok) begin
                    beat_d  = '0;
                    state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (beat_q == LAST_BEAT) begin
                    if (accept) begin
                        wr_d    = cmd_is_wr;
                        dly_d   = dly_load;
                        beat_d  = '0;
                        state_d = fast_go ? ST_XFER : ST_WAIT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    beat_d = beat_q + BEAT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = (state_q == ST_IDLE) || ((state_q == ST_XFER) && (beat_q == LAST_BEAT));
        data_vld  = (state_q == ST_XFER);
        data_wr   = (state_q == ST_XFER) && wr_q;
    end

endmodule

// File: rtl/bus_data_sched_chk.sv
`timescale 1ns/1ps
module bus_data_sched_chk
    import bds_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     cmd_valid,
    input logic     cmd_ready,
    input logic     data_vld,
    input logic     data_wr,
    input logic     cfg_err,
    input bds_cfg_t act_cfg
);

    logic             seen_q;
    logic             lastw_q;
    logic [GAP_W-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            lastw_q <= 1'b0;
            idle_q  <= '0;
        end else if (data_vld) begin
            seen_q  <= 1'b1;
            lastw_q <= data_wr;
            idle_q  <= '0;
        end else if (idle_q != GAP_W'(GAP_MAX)) begin
            idle_q <= idle_q + GAP_W'(1);
        end
    end

    p_dir_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !data_vld |-> !data_wr);

    p_phase_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !cmd_ready) |=> (data_vld && (data_wr == $past(data_wr))));

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_rsvd_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.rd_code == 2'b00) |=> cfg_err);

    p_turn_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !data_wr && seen_q && lastw_q) |-> (idle_q >= GAP_W'(act_cfg.w2r_gap)));

    p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && data_wr && seen_q && !lastw_q) |-> (idle_q >= act_cfg.r2w_gap));

endmodule

bind bus_data_sched bus_data_sched_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .data_vld  (data_vld),
    .data_wr   (data_wr),
    .cfg_err   (cfg_err),
    .act_cfg   (act_cfg)
);

// File: tb/bus_data_sched_tb_top.sv
`timescale 1ns/1ps
module bus_data_sched_tb_top;

    localparam int BEATS = 4;
    localparam int NVEC  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap_rd_dly = 2'd2;
    logic [3:0] strap_wr_dly = 4'd3;
    logic       strap_w2r_gap = 1'b1;
    logic [1:0] strap_r2w_gap = 2'd1;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic       cmd_valid = 1'b0;
    logic       cmd_is_wr = 1'b0;
    logic       cmd_ready, data_vld, data_wr, cfg_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int cyc   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_data_sched #(.BEATS(BEATS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .strap_rd_dly(strap_rd_dly), .strap_wr_dly(strap_wr_dly),
        .strap_w2r_gap(strap_w2r_gap), .strap_r2w_gap(strap_r2w_gap),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr), .cmd_ready(cmd_ready),
        .data_vld(data_vld), .data_wr(data_wr), .cfg_err(cfg_err)
    );

    // Phase and acceptance monitor, sampled mid-cycle
    int   n_beats = 0;
    int   n_acc   = 0;
    int   ph_start [64];
    logic ph_wr    [64];
    int   acc_cyc  [64];

    always @(negedge clk) begin
        if (rst_n) begin
            if (data_vld) begin
                if ((n_beats % BEATS) == 0 && (n_beats / BEATS) < 64) begin
                    ph_start[n_beats / BEATS] = cyc;
                    ph_wr[n_beats / BEATS]    = data_wr;
                end
                n_beats++;
            end
            if (cmd_valid && cmd_ready && n_acc < 64) begin
                acc_cyc[n_acc] = cyc;
                n_acc++;
            end
        end
    end

    // Vector entry: {timing word [10:2], first dir [1], second dir [0]}
    localparam logic [10:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 4'd0,  2'd1, 1'b0, 1'b0},
        {2'd0, 1'b0, 4'd0,  2'd3, 1'b1, 1'b1},
        {2'd3, 1'b0, 4'd5,  2'd2, 1'b0, 1'b1},
        {2'd3, 1'b0, 4'd0,  2'd1, 1'b0, 1'b1},
        {2'd0, 1'b1, 4'd0,  2'd1, 1'b1, 1'b0},
        {2'd0, 1'b1, 4'd0,  2'd3, 1'b1, 1'b0},
        {2'd2, 1'b0, 4'd0,  2'd1, 1'b0, 1'b1},
        {2'd0, 1'b0, 4'd0,  2'd1, 1'b1, 1'b0},
        {2'd0, 1'b0, 4'd15, 2'd1, 1'b1, 1'b1},
        {2'd1, 1'b1, 4'd2,  2'd2, 1'b0, 1'b0}
    };

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_dly(logic [8:0] c, logic wr);
        if (wr) return int'(c[5:2]) + 1;
        return (c[1:0] == 2'b00) ? 1 : int'(c[1:0]);
    endfunction

    function automatic int exp_gap(logic [8:0] c, logic pw, logic nw);
        if (pw == nw) return 0;
        return pw ? int'(c[6]) : int'(c[8:7]);
    endfunction

    task automatic write_cfg(logic [8:0] w);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic issue_one(logic wr);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_is_wr = wr;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        repeat (40) @(posedge clk);
    endtask

    // Two commands back to back; optionally a register write while the first waits.
    task automatic issue_pair(logic wa, logic wb, bit mid_wr, logic [8:0] mid_cfg);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_is_wr = wa;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_is_wr = wb;
        if (mid_wr) begin
            cfg_we = 1'b1; cfg_wdata = mid_cfg;
            @(posedge clk); #1;
            cfg_we = 1'b0;
        end
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        repeat (60) @(posedge clk);
    endtask

    task automatic judge_pair(logic [8:0] c_used, logic wa, logic wb, int p0, int a0);
        int gap_exp;
        gap_exp = exp_dly(c_used, wb) - 1;
        if (exp_gap(c_used, wa, wb) > gap_exp) gap_exp = exp_gap(c_used, wa, wb);
        chk(wa ? "R3 first delay" : "R2 first delay", ph_start[p0] - acc_cyc[a0], exp_dly(c_used, wa));
        chk("R9 second accepted on last beat", acc_cyc[a0 + 1], ph_start[p0] + BEATS - 1);
        chk((wa == wb) ? "R8 idle between phases" : (wa ? "R6 idle after write" : "R7 idle after read"),
            ph_start[p0 + 1] - ph_start[p0] - BEATS, gap_exp);
        chk("R5 first direction", int'(ph_wr[p0]), int'(wa));
        chk("R5 second direction", int'(ph_wr[p0 + 1]), int'(wb));
        chk("R5 beat count", n_beats, (p0 + 2) * BEATS);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int p0;
        int a0;
        logic [8:0] c;
        logic [8:0] strap_word;

        // R1: reset state and strap load
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in reset", int'(cmd_ready), 1);
        chk("R1 no beat in reset", int'(data_vld), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ready after reset", int'(cmd_ready), 1);
        chk("R1 no error after reset", int'(cfg_err), 0);
        strap_word = {strap_r2w_gap, strap_w2r_gap, strap_wr_dly, strap_rd_dly};

        p0 = n_beats / BEATS; a0 = n_acc;
        issue_one(1'b0);
        chk("R1 R2 strapped read delay", ph_start[p0] - acc_cyc[a0], exp_dly(strap_word, 1'b0));
        p0 = n_beats / BEATS; a0 = n_acc;
        issue_one(1'b1);
        chk("R1 R3 strapped write delay", ph_start[p0] - acc_cyc[a0], exp_dly(strap_word, 1'b1));

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            c = VEC[i][10:2];
            write_cfg(c);
            p0 = n_beats / BEATS; a0 = n_acc;
            issue_pair(VEC[i][1], VEC[i][0], 1'b0, '0);
            judge_pair(c, VEC[i][1], VEC[i][0], p0, a0);
        end
        @(negedge clk);
        chk("R4 valid codes leave flag clear", int'(cfg_err), 0);

        // R10: write while busy is deferred past a last-beat acceptance
        c = {2'd0, 1'b0, 4'd15, 2'd1};
        write_cfg(c);
        p0 = n_beats / BEATS; a0 = n_acc;
        issue_pair(1'b1, 1'b1, 1'b1, {2'd0, 1'b0, 4'd0, 2'd1});
        judge_pair(c, 1'b1, 1'b1, p0, a0);
        p0 = n_beats / BEATS; a0 = n_acc;
        issue_one(1'b1);
        chk("R10 new word after idle", ph_start[p0] - acc_cyc[a0], 1);

        // R4: reserved read code
        write_cfg({2'd0, 1'b0, 4'd0, 2'd0});
        @(negedge clk);
        chk("R4 flag set by reserved code", int'(cfg_err), 1);
        p0 = n_beats / BEATS; a0 = n_acc;
        issue_one(1'b0);
        chk("R4 reserved code acts as one clock", ph_start[p0] - acc_cyc[a0], 1);
        write_cfg({2'd0, 1'b0, 4'd0, 2'd3});
        @(negedge clk);
        chk("R4 flag sticky", int'(cfg_err), 1);

        // R1: second reset clears flag and reloads straps
        @(posedge clk); #1;
        rst_n = 1'b0;
        strap_rd_dly = 2'd3;
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 flag cleared by reset", int'(cfg_err), 0);
        chk("R1 ready after second reset", int'(cmd_ready), 1);
        p0 = n_beats / BEATS; a0 = n_acc;
        issue_one(1'b0);
        chk("R1 R2 reloaded strap delay", ph_start[p0] - acc_cyc[a0], 3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule